// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block watches one dedicated external interrupt pin and two groups of general-purpose pins. It turns their activity into three interrupt request lines: one for the external pin, one for the low group (eight pins by default) and one for the high group (four pins by default). Every pin is first brought into the clock domain through a synchroniser. Activity is then judged against the register settings. Edge and change activity is held in sticky flags until the interrupt controller acknowledges it or software clears it.

Software controls the block through a small register port. A control register holds a two-bit sense-mode field in bits 7:6. Its other six bits are plain storage. A group-enable register gates the two pin-change groups. An external-enable register gates the external pin. Two pin-mask registers select which pins of each group take part. A flag register shows the pending requests and is cleared by writing ones. All three requests are also gated by a global interrupt enable input.

Top module: `eint_unit`

## Requirements
- R1: The sense mode is bits 7:6 of the control register (address 0): 00 selects low level, 01 any change, 10 falling edge and 11 rising edge. Bits 5:0 of that register read back what was written.
- R2: Every pin passes through a two-flop synchroniser. A pin change driven before clock edge k shows on the request output after edge k+2. A pin pulse that lasts two or more clock periods always produces a request in the edge and change modes.
- R3: In the edge modes only the selected direction sets the external flag. In change mode both directions set it. Once set, the flag holds until it is cleared.
- R4: In low-level mode the external request follows the synchronised pin level, one edge sooner than edge events. It is not latched and drops once the pin is seen high.
- R5: The external request is given only while the global enable input is high and bit 0 of the external-enable register (address 2) is 1. Gating the request leaves a pending flag intact.
- R6: A change on a group pin whose bit is 1 in that group's mask (address 3 for the low group, address 4 for the high group) sets that group's flag. Changes on unmasked pins do not. A group request is given only while its flag, its group enable and the global enable are all set.
- R7: In the group-enable register (address 1), bit 5 enables the high group and bit 4 the low group. Bits 7:6 and 3:0 read as zero and ignore writes. The external-enable register keeps only bit 0. The high-group mask keeps only its low four bits.
- R8: After reset every register and flag reads zero and all requests are low.
- R9: A flag clears on its acknowledge input or when a one is written to its bit in the flag register. If a new event arrives in the same cycle as a clear, the flag stays set.
- R10: The flag register (address 5) shows the external flag in bit 0, the low-group flag in bit 1 and the high-group flag in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| pc_g0_pins | input | 8 | Low pin-change group, asynchronous |
| pc_g1_pins | input | 4 | High pin-change group, asynchronous |
| gie | input | 1 | Global interrupt enable |
| ack_ext | input | 1 | Acknowledge for the external request |
| ack_pc0 | input | 1 | Acknowledge for the low-group request |
| ack_pc1 | input | 1 | Acknowledge for the high-group request |
| irq_ext | output | 1 | External pin request |
| irq_pc0 | output | 1 | Low-group request |
| irq_pc1 | output | 1 | High-group request |

## Verification
An edge or change request is due three sampling windows after the window in which the pin moved. A low-level request is due two windows later, and read data and gating by the enables show in the same window. Register writes, acknowledges and write-one clears act one window later. Each stimulus task records every expected value together with its window number. The monitor samples just after the falling clock edge and compares each value only in its due window. An expectation that is never compared counts as a miscompare.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
package eint_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_ANY  = 2'b01,
      SNS_FALL = 2'b10,
      SNS_RISE = 2'b11
   } sense_t;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_GEN  = 3'd1;
   localparam logic [ADDR_W-1:0] A_XEN  = 3'd2;
   localparam logic [ADDR_W-1:0] A_PM0  = 3'd3;
   localparam logic [ADDR_W-1:0] A_PM1  = 3'd4;
   localparam logic [ADDR_W-1:0] A_FLG  = 3'd5;

   localparam int NFLAG = 3;   // 0 external, 1 low group, 2 high group
endpackage

// File: rtl/eint_sync.sv
`timescale 1ns/1ps
module eint_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eint_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/eint_edge.sv
`timescale 1ns/1ps
module eint_edge #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;
endmodule

// File: rtl/eint_sticky.sv
`timescale 1ns/1ps
module eint_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
         end

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);                                         // R9
         AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flag[i]);                           // R9
         AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !set[i]) |=> $stable(flag[i]));                  // R3
      end
   endgenerate
endmodule

// File: rtl/eint_unit.sv
`timescale 1ns/1ps
module eint_unit
   import eint_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int G0_W        = 8,
   parameter int G1_W        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int EN_BIT_G1   = 5,
   parameter int EN_BIT_G0   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ext_pin,
   input  logic [G0_W-1:0]   pc_g0_pins,
   input  logic [G1_W-1:0]   pc_g1_pins,
   input  logic              gie,
   input  logic              ack_ext,
   input  logic              ack_pc0,
   input  logic              ack_pc1,
   output logic              irq_ext,
   output logic              irq_pc0,
   output logic              irq_pc1
);
   localparam int PW    = 1 + G0_W + G1_W;
   localparam int MODE_LSB = DATA_W - 2;

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("eint_unit: DATA_W must be at least 8");
      end
      if (G0_W < 1 || G0_W > DATA_W) begin : g_bad_g0
         $error("eint_unit: G0_W out of range");
      end
      if (G1_W < 1 || G1_W > DATA_W) begin : g_bad_g1
         $error("eint_unit: G1_W out of range");
      end
      if (EN_BIT_G0 == EN_BIT_G1 || EN_BIT_G0 >= MODE_LSB || EN_BIT_G1 >= MODE_LSB) begin : g_bad_en
         $error("eint_unit: group enable bits collide");
      end
   endgenerate

   // ---------------- registers ----------------
   logic [DATA_W-1:0] ctrl_q;
   logic [1:0]        gen_q;     // [1] high group, [0] low group
   logic              xen_q;
   logic [G0_W-1:0]   pm0_q;
   logic [G1_W-1:0]   pm1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         gen_q  <= '0;
         xen_q  <= 1'b0;
         pm0_q  <= '0;
         pm1_q  <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_CTRL: ctrl_q <= reg_wdata;
            A_GEN:  gen_q  <= {reg_wdata[EN_BIT_G1], reg_wdata[EN_BIT_G0]};
            A_XEN:  xen_q  <= reg_wdata[0];
            A_PM0:  pm0_q  <= reg_wdata[G0_W-1:0];
            A_PM1:  pm1_q  <= reg_wdata[G1_W-1:0];
            default: ;
         endcase
      end
   end

   sense_t mode;
   assign mode = sense_t'(ctrl_q[DATA_W-1 -: 2]);

   // ---------------- pin path ----------------
   logic [PW-1:0] pin_raw, pin_s, rise, fall, chg;
   assign pin_raw = {pc_g1_pins, pc_g0_pins, ext_pin};

   eint_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
   );

   eint_edge #(.W(PW)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur(pin_s), .rise(rise), .fall(fall)
   );

   assign chg = rise | fall;

   logic ext_evt, g0_evt, g1_evt;
   always_comb begin
      case (mode)
         SNS_ANY:  ext_evt = chg[0];
         SNS_FALL: ext_evt = fall[0];
         SNS_RISE: ext_evt = rise[0];
         default:  ext_evt = 1'b0;
      endcase
   end
   assign g0_evt = |(chg[G0_W:1] & pm0_q);
   assign g1_evt = |(chg[PW-1 -: G1_W] & pm1_q);

   // ---------------- sticky flags ----------------
   logic [NFLAG-1:0] flg, set_v, clr_v, w1c;
   assign w1c   = (reg_wr && reg_addr == A_FLG) ? reg_wdata[NFLAG-1:0] : '0;
   assign set_v = {g1_evt, g0_evt, ext_evt};
   assign clr_v = {ack_pc1, ack_pc0, ack_ext} | w1c;

   eint_sticky #(.N(NFLAG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .flag(flg)
   );

   // ---------------- requests ----------------
   assign irq_ext = gie && xen_q && ((mode == SNS_LOW) ? !pin_s[0] : flg[0]);
   assign irq_pc0 = gie && gen_q[0] && flg[1];
   assign irq_pc1 = gie && gen_q[1] && flg[2];

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata = ctrl_q;
         A_GEN: begin
            reg_rdata[EN_BIT_G1] = gen_q[1];
            reg_rdata[EN_BIT_G0] = gen_q[0];
         end
         A_XEN:  reg_rdata[0] = xen_q;
         A_PM0:  reg_rdata[G0_W-1:0] = pm0_q;
         A_PM1:  reg_rdata[G1_W-1:0] = pm1_q;
         A_FLG:  reg_rdata[NFLAG-1:0] = flg;
         default: ;
      endcase
   end

   // ---------------- checks ----------------
   AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> (!irq_ext && !irq_pc0 && !irq_pc1));                       // R5
   AST_GROUP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pc0 || irq_pc1) |-> (flg[1] || flg[2]));                       // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_GEN) |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[3:0] == 4'h0)); // R7
   AST_LOW_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SNS_LOW && pin_s[0]) |-> !irq_ext);                        // R4
endmodule

// File: tb/tb_eint_unit.sv
`timescale 1ns/1ps
module tb_eint_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ext_pin = 1'b1;
   logic [7:0] pc_g0_pins = '0;
   logic [3:0] pc_g1_pins = '0;
   logic       gie = 1'b0;
   logic       ack_ext = 1'b0, ack_pc0 = 1'b0, ack_pc1 = 1'b0;
   logic       irq_ext, irq_pc0, irq_pc1;

   eint_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
      .pc_g0_pins(pc_g0_pins), .pc_g1_pins(pc_g1_pins), .gie(gie),
      .ack_ext(ack_ext), .ack_pc0(ack_pc0), .ack_pc1(ack_pc1),
      .irq_ext(irq_ext), .irq_pc0(irq_pc0), .irq_pc1(irq_pc1)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // kind: 0 irq_ext, 1 irq_pc0, 2 irq_pc1, 3 reg_rdata
   typedef struct {
      int         due;
      int         kind;
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;

   task automatic expect_at(input int kind, input logic [7:0] val, input int dly, input string tag);
      exp_t e;
      e.due = cyc + dly; e.kind = kind; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: samples 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         for (int i = 0; i < q.size(); ) begin
            if (q[i].due <= cyc) begin
               logic [7:0] act;
               case (q[i].kind)
                  0: act = {7'd0, irq_ext};
                  1: act = {7'd0, irq_pc0};
                  2: act = {7'd0, irq_pc1};
                  default: act = reg_rdata;
               endcase
               n_chk++;
               if (q[i].due < cyc || act !== q[i].val) begin
                  n_bad++;
                  $display("FAIL %s kind=%0d: actual %h expected %h (due %0d at %0d)",
                           q[i].tag, q[i].kind, act, q[i].val, q[i].due, cyc);
               end
               q.delete(i);
            end else begin
               i++;
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] v, input string tag);
      reg_addr = a;
      expect_at(3, v, 0, tag);
      tick(1);
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R8 reset state
      expect_at(0, 0, 0, "R8 irq_ext"); expect_at(1, 0, 0, "R8 irq_pc0"); expect_at(2, 0, 0, "R8 irq_pc1");
      for (int a = 0; a < 6; a++) rd(a[2:0], 8'h00, "R8 reset read");

      // R7 / R1 register storage
      wr(3'd0, 8'h3F); rd(3'd0, 8'h3F, "R1 ctrl low bits");
      wr(3'd1, 8'hFF); rd(3'd1, 8'h30, "R7 group enable mask");
      wr(3'd2, 8'hFF); rd(3'd2, 8'h01, "R7 ext enable width");
      wr(3'd3, 8'hA5); rd(3'd3, 8'hA5, "R7 low mask");
      wr(3'd4, 8'hFF); rd(3'd4, 8'h0F, "R7 high mask width");
      wr(3'd1, 8'h30); wr(3'd2, 8'h01); wr(3'd3, 8'h08); wr(3'd4, 8'h02);
      wr(3'd0, 8'h00);
      gie = 1'b1;
      tick(2);

      // R4 low level, follows pin
      ext_pin = 1'b0;
      expect_at(0, 0, 1, "R4 level not yet"); expect_at(0, 1, 2, "R4 level asserted");
      tick(4);
      ext_pin = 1'b1;
      expect_at(0, 1, 1, "R4 still low seen"); expect_at(0, 0, 2, "R4 released");
      tick(4);
      rd(3'd5, 8'h00, "R4 no flag latched");
      // R5 global enable gating
      ext_pin = 1'b0; tick(3);
      gie = 1'b0; expect_at(0, 0, 0, "R5 gie off");
      tick(1);
      gie = 1'b1; expect_at(0, 1, 0, "R5 gie on");
      tick(1);
      ext_pin = 1'b1; tick(4);

      // R3 falling edge, R2 two-cycle pulse
      wr(3'd0, 8'h80);
      ext_pin = 1'b0;
      expect_at(0, 0, 2, "R2 not before edge k+2"); expect_at(0, 1, 3, "R2 fall request");
      tick(2);
      ext_pin = 1'b1;
      expect_at(0, 1, 4, "R3 sticky after pulse");
      tick(5);
      rd(3'd5, 8'h01, "R10 ext flag bit0");
      ack_ext = 1'b1; tick(1); ack_ext = 1'b0;
      expect_at(0, 0, 0, "R9 ack clears");
      tick(1);

      // R3 rising mode ignores falling
      wr(3'd0, 8'hC0);
      ext_pin = 1'b0; expect_at(0, 0, 3, "R3 rise mode ignores fall");
      tick(4);
      ext_pin = 1'b1; expect_at(0, 0, 2, "R2 rise latency"); expect_at(0, 1, 3, "R3 rise request");
      tick(4);
      wr(3'd5, 8'h01); expect_at(0, 0, 0, "R9 write-one clear");
      tick(1);

      // R1 any-change mode, R5 ext enable, R9 set wins
      wr(3'd0, 8'h40);
      ext_pin = 1'b0; expect_at(0, 1, 3, "R1 any change falling");
      tick(4);
      wr(3'd2, 8'h00); expect_at(0, 0, 0, "R5 ext enable off");
      rd(3'd5, 8'h01, "R5 flag kept while gated");
      wr(3'd2, 8'h01); expect_at(0, 1, 0, "R5 ext enable on");
      ext_pin = 1'b1;
      tick(2);
      ack_ext = 1'b1; tick(1); ack_ext = 1'b0;
      expect_at(0, 1, 0, "R9 set wins over ack");
      tick(1);
      expect_at(0, 1, 0, "R9 still set");
      ack_ext = 1'b1; tick(1); ack_ext = 1'b0;
      expect_at(0, 0, 0, "R9 ack after set");
      tick(1);

      // R6 low group, mask 0x08
      pc_g0_pins[5] = 1'b1;
      expect_at(1, 0, 3, "R6 unmasked pin"); expect_at(1, 0, 5, "R6 unmasked pin late");
      tick(6);
      pc_g0_pins[3] = 1'b1;
      expect_at(1, 1, 3, "R6 masked pin request"); expect_at(2, 0, 3, "R6 other group quiet");
      tick(4);
      rd(3'd5, 8'h02, "R10 low group flag bit1");
      ack_pc0 = 1'b1; tick(1); ack_pc0 = 1'b0;
      expect_at(1, 0, 0, "R9 group ack");
      tick(1);
      pc_g0_pins[3] = 1'b0; expect_at(1, 1, 3, "R6 falling change counts");
      tick(4);
      wr(3'd5, 8'h02); expect_at(1, 0, 0, "R9 group write-one clear");
      tick(1);

      // R6 high group, enable gating
      wr(3'd1, 8'h10);
      pc_g1_pins[1] = 1'b1; expect_at(2, 0, 3, "R6 group disabled");
      tick(4);
      rd(3'd5, 8'h04, "R10 high group flag bit2");
      wr(3'd1, 8'h30); expect_at(2, 1, 0, "R6 group enabled");
      tick(1);
      gie = 1'b0; expect_at(2, 0, 0, "R5 gie gates group");
      tick(1);
      gie = 1'b1;
      wr(3'd5, 8'h04); expect_at(2, 0, 0, "R9 high group clear");
      tick(3);

      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 pending: actual %0d expected 0", q.size());
      end
      finish_run();
   end
endmodule